// File: doc/BRIEF.md
# Selectable PRBS Pattern Generator

This block generates a pseudorandom binary sequence for link testing and produces DATA_W bits on every enabled clock. One unrolled Fibonacci shift engine serves five standard sequence lengths: 7, 9, 15, 23 and 31. A three-bit select input picks the length. The longer three sequences are sent out inverted. The engine keeps a 31-bit history of recently generated bits. Each new bit is the XOR of two history taps that the chosen pattern fixes. Within a cycle the engine steps once for every output bit.

The generator is used as the transmit side of a bit-error test. After reset, or after loading a seed, it runs from a known state, and every clock with the enable high produces the next word of the stream. The bit that was generated first sits in bit 0 of the word. The select input is captured only at reset or at a seed load, so a running stream never changes pattern partway through. A seed that would put the register in the stuck all-zero state is replaced by all ones.

Top module: `prbs_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `data_out` becomes zero, every history bit becomes one, and the pattern is captured from `sel`.
- R2: At each edge with `en` high, and with `rst` and `seed_load` low, `data_out` takes the next DATA_W generated bits. The earliest of them is in bit 0. The word is visible right after that edge.
- R3: With history h (h[0] is the newest bit), every new bit equals h[n-1] XOR h[m-1], and the history then shifts up with the new bit entering h[0]. The `sel` codes give (n,m): 0 → (7,6), 1 → (9,5), 2 → (15,14), 3 → (23,18), 4 → (31,28).
- R4: For `sel` codes 2, 3 and 4, each generated bit is inverted before it reaches `data_out`. For codes 0 and 1 it is not inverted.
- R5: At an edge with `en` low, and with `rst` and `seed_load` low, `data_out` and the sequence position do not change.
- R6: Any change of `sel` outside reset or a seed load has no effect. The stream keeps the pattern it already had.
- R7: At an edge with `seed_load` high, the history takes `seed_value` (bit 0 is the newest bit) and the pattern is captured from `sel`. `data_out` holds its value, and `en` is ignored for that edge.
- R8: If the lowest n history bits of the active pattern would become all zero, all ones are stored instead, so the stream cannot lock up.
- R9: The `sel` codes 5, 6 and 7 behave exactly as code 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the sequence by one word |
| sel | input | 3 | Pattern select code |
| seed_load | input | 1 | Load `seed_value` into the history |
| seed_value | input | 31 | Seed history bits, bit 0 newest |
| data_out | output | DATA_W | Generated word, bit 0 earliest |

## Verification
The generated bits come only from the history register, so a wrong history bit or a wrong tap shows at `data_out` on the next enabled word. It then keeps spreading through every later word, and comparing each enabled word with a reference model catches it at once. A wrong captured pattern shows as a mismatch in the first word after reset or seed load. A wrong inversion flag flips every bit of the very first word. An independent period check confirms the 7-bit pattern repeats after 127 bits. A mistake in the hold or load paths shows on the edge where the word should have stayed the same.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

    localparam int HIST_W = 31;
    localparam int IDX_W  = $clog2(HIST_W);

    typedef enum logic [2:0] {
        PAT_7  = 3'd0,
        PAT_9  = 3'd1,
        PAT_15 = 3'd2,
        PAT_23 = 3'd3,
        PAT_31 = 3'd4
    } pat_e;

    typedef struct packed {
        logic [IDX_W-1:0] len_idx;   // register length minus one
        logic [IDX_W-1:0] tap_idx;   // inner tap minus one
        logic             inv;       // invert generated bits
    } pat_cfg_t;

    function automatic pat_cfg_t pat_decode(input logic [2:0] sel);
        pat_cfg_t c;
        case (pat_e'(sel))
            PAT_7:   c = '{len_idx: IDX_W'(6),  tap_idx: IDX_W'(5),  inv: 1'b0};
            PAT_9:   c = '{len_idx: IDX_W'(8),  tap_idx: IDX_W'(4),  inv: 1'b0};
            PAT_15:  c = '{len_idx: IDX_W'(14), tap_idx: IDX_W'(13), inv: 1'b1};
            PAT_23:  c = '{len_idx: IDX_W'(22), tap_idx: IDX_W'(17), inv: 1'b1};
            default: c = '{len_idx: IDX_W'(30), tap_idx: IDX_W'(27), inv: 1'b1};
        endcase
        return c;
    endfunction

    function automatic logic [HIST_W-1:0] window_mask(input logic [IDX_W-1:0] len_idx);
        logic [HIST_W-1:0] m;
        for (int i = 0; i < HIST_W; i++) begin
            m[i] = (i <= int'(len_idx));
        end
        return m;
    endfunction

    // Replace a dead (all-zero) active window by all ones.
    function automatic logic [HIST_W-1:0] guard_lockup(input logic [HIST_W-1:0] h,
                                                       input pat_cfg_t      cfg);
        if ((h & window_mask(cfg.len_idx)) == '0) begin
            return '1;
        end
        return h;
    endfunction

endpackage

// File: rtl/prbs_step.sv
module prbs_step
    import prbs_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [HIST_W-1:0] hist_in,
    input  pat_cfg_t          cfg,
    output logic [HIST_W-1:0] hist_out,
    output logic [DATA_W-1:0] word
);

    logic [HIST_W-1:0] chain [DATA_W+1];

    assign chain[0] = hist_in;

    genvar i;
    generate
        for (i = 0; i < DATA_W; i++) begin : g_bit
            logic fb;
            assign fb          = chain[i][cfg.len_idx] ^ chain[i][cfg.tap_idx];
            assign word[i]     = fb ^ cfg.inv;
            assign chain[i+1]  = {chain[i][HIST_W-2:0], fb};
        end
    endgenerate

    assign hist_out = chain[DATA_W];

endmodule

// File: rtl/prbs_state.sv
module prbs_state
    import prbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [2:0]        sel,
    input  logic              seed_load,
    input  logic [HIST_W-1:0] seed_value,
    input  logic [HIST_W-1:0] hist_step,
    output logic [HIST_W-1:0] hist_q,
    output pat_cfg_t          cfg_q
);

    pat_cfg_t          sel_cfg;
    logic [HIST_W-1:0] hist_d;

    assign sel_cfg = pat_decode(sel);

    always_comb begin
        hist_d = hist_q;
        if (seed_load) begin
            hist_d = guard_lockup(seed_value, sel_cfg);
        end else if (en) begin
            hist_d = guard_lockup(hist_step, cfg_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '1;
            cfg_q  <= sel_cfg;
        end else begin
            hist_q <= hist_d;
            if (seed_load) begin
                cfg_q <= sel_cfg;
            end
        end
    end

    // R6: captured pattern only moves on reset or seed load
    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(seed_load)) |-> (cfg_q == $past(cfg_q)));

    // R8: the active window of the history is never all zero
    p_window_live_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((hist_q & window_mask(cfg_q.len_idx)) != '0));

    // R7: a load places the (guarded) seed in the history
    p_seed_taken_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(seed_load) &&
         (($past(seed_value) & window_mask(cfg_q.len_idx)) != '0))
        |-> (hist_q == $past(seed_value)));

endmodule

// File: rtl/prbs_gen.sv
module prbs_gen
    import prbs_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [2:0]        sel,
    input  logic              seed_load,
    input  logic [HIST_W-1:0] seed_value,
    output logic [DATA_W-1:0] data_out
);

    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_step;
    pat_cfg_t          cfg_q;
    logic [DATA_W-1:0] word_d;
    logic [DATA_W-1:0] word_q;

    prbs_step #(
        .DATA_W (DATA_W)
    ) u_step (
        .hist_in  (hist_q),
        .cfg      (cfg_q),
        .hist_out (hist_step),
        .word     (word_d)
    );

    prbs_state u_state (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .sel        (sel),
        .seed_load  (seed_load),
        .seed_value (seed_value),
        .hist_step  (hist_step),
        .hist_q     (hist_q),
        .cfg_q      (cfg_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (en && !seed_load) begin
            word_q <= word_d;
        end
    end

    assign data_out = word_q;

    // R1: the cycle after reset shows a zero word
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (data_out == '0));

    // R5 / R7: no advance means a held word
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (!$past(en) || $past(seed_load))) |-> $stable(data_out));

endmodule

// File: tb/prbs_gen_bench.sv
module prbs_gen_bench;

    localparam int DW = 32;
    localparam int HW = 31;

    typedef struct {
        logic [DW-1:0] exp;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic [2:0]    sel = 3'd0;
    logic          seed_load = 1'b0;
    logic [HW-1:0] seed_value = '0;
    logic [DW-1:0] data_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    item_t sb[$];

    // reference model state
    logic [HW-1:0] m_hist;
    int            m_n;
    int            m_m;
    logic          m_inv;
    logic [DW-1:0] m_out;

    always #4 clk = ~clk;

    prbs_gen #(
        .DATA_W (DW)
    ) u_prbs_gen (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .sel        (sel),
        .seed_load  (seed_load),
        .seed_value (seed_value),
        .data_out   (data_out)
    );

    task automatic model_cfg(input logic [2:0] s);
        case (s)
            3'd0:    begin m_n = 7;  m_m = 6;  m_inv = 1'b0; end
            3'd1:    begin m_n = 9;  m_m = 5;  m_inv = 1'b0; end
            3'd2:    begin m_n = 15; m_m = 14; m_inv = 1'b1; end
            3'd3:    begin m_n = 23; m_m = 18; m_inv = 1'b1; end
            default: begin m_n = 31; m_m = 28; m_inv = 1'b1; end
        endcase
    endtask

    function automatic bit window_zero(input logic [HW-1:0] h, input int n);
        for (int i = 0; i < n; i++) begin
            if (h[i]) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic model_step();
        logic fb;
        for (int k = 0; k < DW; k++) begin
            fb       = m_hist[m_n-1] ^ m_hist[m_m-1];
            m_out[k] = fb ^ m_inv;
            m_hist   = {m_hist[HW-2:0], fb};
        end
        if (window_zero(m_hist, m_n)) m_hist = '1;
    endtask

    task automatic push(input logic [DW-1:0] e, input string tag);
        item_t it;
        it.exp = e;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic do_reset(input logic [2:0] s, input string tag);
        @(negedge clk);
        rst = 1'b1; en = 1'b0; seed_load = 1'b0; sel = s;
        m_hist = '1; model_cfg(s); m_out = '0;
        push(m_out, tag);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_cycle(input logic e, input logic [2:0] s, input string tag);
        @(negedge clk);
        en = e; sel = s; seed_load = 1'b0;
        if (e) model_step();
        push(m_out, tag);
    endtask

    task automatic do_load(input logic [HW-1:0] sd, input logic [2:0] s, input string tag);
        @(negedge clk);
        en = 1'b1; sel = s; seed_load = 1'b1; seed_value = sd;
        model_cfg(s);
        m_hist = sd;
        if (window_zero(m_hist, m_n)) m_hist = '1;
        push(m_out, tag);
        @(negedge clk);
        seed_load = 1'b0; en = 1'b0;
        push(m_out, tag);
    endtask

    task automatic check(input bit ok, input string tag,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares each posted expectation just after its edge
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(data_out === it.exp, it.tag, data_out, it.exp);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] first_word;

        // R1 reset, then R2/R3 with the 7-bit pattern
        do_reset(3'd0, "R1 reset word");
        for (int i = 0; i < 8; i++) do_cycle(1'b1, 3'd0, "R2 R3 prbs7 word");

        // R5 hold with enable low
        for (int i = 0; i < 3; i++) do_cycle(1'b0, 3'd0, "R5 hold");
        do_cycle(1'b1, 3'd0, "R5 resume position");

        // R6 select change mid-stream is ignored
        for (int i = 0; i < 5; i++) do_cycle(1'b1, 3'd3, "R6 select ignored");

        // R3/R4 each other pattern from reset
        for (int s = 1; s <= 4; s++) begin
            do_reset(3'(s), "R1 reset word");
            for (int i = 0; i < 6; i++) do_cycle(1'b1, 3'(s), "R3 R4 pattern word");
        end

        // R9 spare codes act as the 31-bit pattern
        do_reset(3'd6, "R1 reset word");
        for (int i = 0; i < 6; i++) do_cycle(1'b1, 3'd6, "R9 spare code");
        do_reset(3'd7, "R1 reset word");
        for (int i = 0; i < 3; i++) do_cycle(1'b1, 3'd7, "R9 spare code");

        // R7 seed load holds output, ignores enable, captures pattern
        do_load(31'h1234_5678, 3'd1, "R7 load holds word");
        for (int i = 0; i < 5; i++) do_cycle(1'b1, 3'd1, "R7 seeded stream");
        do_load(31'h0000_0055, 3'd2, "R7 load holds word");
        for (int i = 0; i < 5; i++) do_cycle(1'b1, 3'd2, "R7 R4 seeded stream");

        // R8 dead seed window replaced by ones
        do_load(31'h7FFF_FF80, 3'd0, "R8 zero window load");
        for (int i = 0; i < 4; i++) do_cycle(1'b1, 3'd0, "R8 recovered stream");
        do_load(31'h0, 3'd4, "R8 zero seed load");
        for (int i = 0; i < 4; i++) do_cycle(1'b1, 3'd4, "R8 recovered stream");

        // R3 independent period check: 7-bit pattern repeats every 127 bits
        do_reset(3'd0, "R1 reset word");
        do_cycle(1'b1, 3'd0, "R3 period start");
        @(posedge clk); #2;
        first_word = data_out;
        for (int i = 0; i < 127; i++) do_cycle(1'b1, 3'd0, "R3 period run");
        @(negedge clk);
        en = 1'b0;
        @(posedge clk); #3;
        check(data_out === first_word, "R3 period 127", data_out, first_word);

        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule